// File: doc/BRIEF.md
# Cascadable Dual Event Counter

Two 8-bit up-counters tally rising edges seen on two external event pins. Each pin passes through a two-flop synchronizer and a rising-edge detector. The low counter always counts its own pin. A control bit picks the source of the high counter:

- In independent mode, the high counter counts its own pin, so the block acts as two 8-bit counters.
- In cascade mode, the high counter takes the low counter's wrap pulse in the same cycle, so the pair forms one coherent 16-bit counter.

A small register bus reads both counts and gives each half a software clear. A clock-stop register holds a run bit that freezes counting in module standby.

Register map (2-bit address, 8-bit data):

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | low count | read-only |
| 2 | high count | read-only |
| 3 | clock-stop | read/write |

Reads are combinational from `bus_addr_i`. Writes take effect on the clock edge where `bus_sel_i` and `bus_we_i` are both high.

Top module: `evt_pair_counter`

## Requirements
- R1: On reset both counts read 0x00, the control register reads 0x00 and the clock-stop register (address 3) reads 0xFF.
- R2: The low count (address 1) rises by exactly one for each rising edge on `evt_lo_i`, no later than 4 clock cycles after the edge. An input held high counts once.
- R3: The low count wraps from 0xFF to 0x00.
- R4: With control bit 0 set to 1 (cascade), the high count (address 2) rises by one in the same cycle as each low-count wrap, and edges on `evt_hi_i` are ignored.
- R5: With control bit 0 at 0 (independent), the high count rises once per rising edge on `evt_hi_i`, wraps from 0xFF to 0x00, and ignores low-count wraps.
- R6: A write to control with bit 1 set clears the low count, and with bit 2 set clears the high count. These bits read back as 0. A clear wins over a count in the same cycle.
- R7: With clock-stop bit 3 at 0 (standby), neither count changes on events, and edges arriving during standby are lost. Setting bit 3 to 1 resumes counting.
- R8: All eight clock-stop bits are read/write.
- R9: Writes to addresses 1 and 2 leave the counts unchanged.
- R10: Changing control bit 0 leaves both count values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_lo_i | input | 1 | Asynchronous event input for the low counter |
| evt_hi_i | input | 1 | Asynchronous event input for the high counter |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable, qualified by bus_sel_i |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |

## Verification
Pulse trains on the low pin alone show plain counting and the 0xFF to 0x00 wrap. The same train, repeated in cascade mode, separates a carry into the high count from a count on the high pin, because high-pin pulses in that mode must leave the high count unchanged. In independent mode, high-pin trains long enough to wrap, followed by a full low wrap, show that the two halves are truly decoupled. An event edge timed to land on the same cycle as a clear write, and pulses sent during standby, cover the priority and gating corners.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LO    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HI    = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CKSTP = 2'd3;

  localparam int CTRL_CASC_BIT   = 0;
  localparam int CTRL_CLR_LO_BIT = 1;
  localparam int CTRL_CLR_HI_BIT = 2;
  localparam int CKSTP_RUN_BIT   = 3;

  typedef enum logic {
    SRC_OWN_PIN = 1'b0,
    SRC_LO_WRAP = 1'b1
  } hi_src_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic edge_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], evt_i};
  end

  assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/evt_cnt.sv
module evt_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~clr_i & (&cnt_q);
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_cnt_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output hi_src_e           hi_src_o,
  output logic              run_o,
  output logic              clr_lo_o,
  output logic              clr_hi_o,
  output logic [DW-1:0]     ctrl_rd_o,
  output logic [DW-1:0]     ckstp_o
);
  logic    wr_ctrl, wr_ckstp;
  hi_src_e hi_src_q;
  logic [DW-1:0] ckstp_q;

  assign wr_ctrl  = bus_sel_i & bus_we_i & (bus_addr_i == ADDR_CTRL);
  assign wr_ckstp = bus_sel_i & bus_we_i & (bus_addr_i == ADDR_CKSTP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_src_q <= SRC_OWN_PIN;
      ckstp_q  <= '1;
    end else begin
      if (wr_ctrl)  hi_src_q <= hi_src_e'(bus_wdata_i[CTRL_CASC_BIT]);
      if (wr_ckstp) ckstp_q  <= bus_wdata_i;
    end
  end

  // clear bits are write-only strobes
  assign clr_lo_o  = wr_ctrl & bus_wdata_i[CTRL_CLR_LO_BIT];
  assign clr_hi_o  = wr_ctrl & bus_wdata_i[CTRL_CLR_HI_BIT];
  assign hi_src_o  = hi_src_q;
  assign run_o     = ckstp_q[CKSTP_RUN_BIT];
  assign ckstp_o   = ckstp_q;
  assign ctrl_rd_o = {{(DW-1){1'b0}}, hi_src_q};
endmodule

// File: rtl/evt_pair_counter.sv
module evt_pair_counter
  import evt_cnt_pkg::*;
#(
  parameter int W           = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_lo_i,
  input  logic              evt_hi_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o
);
  localparam int NCH = 2;
  localparam int LO  = 0;
  localparam int HI  = 1;

  logic [NCH-1:0] evt_raw, evt_edge;
  logic           inc_lo, inc_hi, wrap_lo, wrap_hi;
  logic           clr_lo, clr_hi, run;
  hi_src_e        hi_src;
  logic [W-1:0]   cnt_lo, cnt_hi, ctrl_rd, ckstp;

  assign evt_raw = {evt_hi_i, evt_lo_i};

  for (genvar g = 0; g < NCH; g++) begin : g_sync
    evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_raw[g]),
      .edge_o (evt_edge[g])
    );
  end

  evt_regs #(.DW(W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .hi_src_o    (hi_src),
    .run_o       (run),
    .clr_lo_o    (clr_lo),
    .clr_hi_o    (clr_hi),
    .ctrl_rd_o   (ctrl_rd),
    .ckstp_o     (ckstp)
  );

  assign inc_lo = run & evt_edge[LO];
  // cascade carry lands in the same cycle as the low wrap
  assign inc_hi = run & ((hi_src == SRC_LO_WRAP) ? wrap_lo : evt_edge[HI]);

  evt_cnt #(.W(W)) u_cnt_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc_lo),
    .clr_i  (clr_lo),
    .cnt_o  (cnt_lo),
    .wrap_o (wrap_lo)
  );

  evt_cnt #(.W(W)) u_cnt_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc_hi),
    .clr_i  (clr_hi),
    .cnt_o  (cnt_hi),
    .wrap_o (wrap_hi)
  );

  always_comb begin
    unique case (bus_addr_i)
      ADDR_CTRL:  bus_rdata_o = ctrl_rd;
      ADDR_LO:    bus_rdata_o = cnt_lo;
      ADDR_HI:    bus_rdata_o = cnt_hi;
      default:    bus_rdata_o = ckstp;
    endcase
  end

  logic unused_wrap_hi;
  assign unused_wrap_hi = wrap_hi;
endmodule

// File: rtl/evt_pair_counter_chk.sv
module evt_pair_counter_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         edge_lo,
  input logic         edge_hi,
  input logic         run,
  input logic         casc,
  input logic         clr_lo,
  input logic         clr_hi,
  input logic         wrap_lo,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi
);
  p_lo_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_lo && run && !clr_lo) |=> cnt_lo == W'($past(cnt_lo) + 1'b1));

  p_edge_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_lo |=> !edge_lo);

  p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_lo |=> cnt_lo == '0);

  p_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc && wrap_lo && !clr_hi) |=> cnt_hi == W'($past(cnt_hi) + 1'b1));

  p_indep_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!casc && !edge_hi && !clr_hi) |=> $stable(cnt_hi));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_lo || clr_hi) |=> ((!$past(clr_lo) || cnt_lo == '0) &&
                            (!$past(clr_hi) || cnt_hi == '0)));

  p_standby_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !clr_lo && !clr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

bind evt_pair_counter evt_pair_counter_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .edge_lo (evt_edge[0]),
  .edge_hi (evt_edge[1]),
  .run     (run),
  .casc    (hi_src == evt_cnt_pkg::SRC_LO_WRAP),
  .clr_lo  (clr_lo),
  .clr_hi  (clr_hi),
  .wrap_lo (wrap_lo),
  .cnt_lo  (cnt_lo),
  .cnt_hi  (cnt_hi)
);

// File: tb/evt_pair_counter_bench.sv
`timescale 1ns/1ps
module evt_pair_counter_bench;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PL = 2'd2, OP_PH = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 2'd3, 8'h00, 8'hFF, 4'd1},  // R1 clock-stop reset
    '{OP_RD, 2'd0, 8'h00, 8'h00, 4'd1},  // R1 control reset
    '{OP_RD, 2'd1, 8'h00, 8'h00, 4'd1},  // R1 low reset
    '{OP_PL, 2'd0, 8'd3,  8'h00, 4'd2},  // R2
    '{OP_RD, 2'd1, 8'h00, 8'h03, 4'd2},  // R2
    '{OP_PH, 2'd0, 8'd2,  8'h00, 4'd5},  // R5
    '{OP_RD, 2'd2, 8'h00, 8'h02, 4'd5},  // R5
    '{OP_WR, 2'd1, 8'h55, 8'h00, 4'd9},  // R9
    '{OP_RD, 2'd1, 8'h00, 8'h03, 4'd9},  // R9
    '{OP_WR, 2'd0, 8'h02, 8'h00, 4'd6},  // R6 clear low
    '{OP_RD, 2'd1, 8'h00, 8'h00, 4'd6},  // R6
    '{OP_RD, 2'd2, 8'h00, 8'h02, 4'd6},  // R6 high untouched
    '{OP_RD, 2'd0, 8'h00, 8'h00, 4'd6},  // R6 strobe reads 0
    '{OP_WR, 2'd3, 8'hF7, 8'h00, 4'd7},  // R7 standby
    '{OP_PL, 2'd0, 8'd2,  8'h00, 4'd7},  // R7
    '{OP_RD, 2'd1, 8'h00, 8'h00, 4'd7},  // R7 frozen
    '{OP_RD, 2'd3, 8'h00, 8'hF7, 4'd8},  // R8
    '{OP_WR, 2'd3, 8'hFF, 8'h00, 4'd7},  // R7 resume
    '{OP_PL, 2'd0, 8'd1,  8'h00, 4'd7},  // R7
    '{OP_RD, 2'd1, 8'h00, 8'h01, 4'd7}   // R7
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       evt_lo_i = 1'b0, evt_hi_i = 1'b0;
  logic       bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [1:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  evt_pair_counter u_evt_pair_counter (.*);

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk_i);
    bus_addr_i = a;
    #1;
    n_chk++;
    if (bus_rdata_o !== e) begin
      n_fail++;
      $display("FAIL %s addr %0d: got %02h expected %02h", tag, a, bus_rdata_o, e);
    end
  endtask

  task automatic pulse(input bit hi, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); if (hi) evt_hi_i = 1'b1; else evt_lo_i = 1'b1;
      @(negedge clk_i);
      @(negedge clk_i); if (hi) evt_hi_i = 1'b0; else evt_lo_i = 1'b0;
      @(negedge clk_i);
    end
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        OP_WR: wr(VECS[v].addr, VECS[v].data);
        OP_RD: rd(VECS[v].addr, VECS[v].exp, $sformatf("R%0d vec %0d", VECS[v].req, v));
        OP_PL: pulse(1'b0, int'(VECS[v].data));
        default: pulse(1'b1, int'(VECS[v].data));
      endcase
    end
    // low=01 high=02: held-high input counts once (R2)
    @(negedge clk_i); evt_lo_i = 1'b1;
    repeat (20) @(negedge clk_i);
    rd(2'd1, 8'h02, "R2 held high");
    @(negedge clk_i); evt_lo_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // cascade select keeps counts (R10), high pin ignored (R4)
    wr(2'd0, 8'h01);
    rd(2'd0, 8'h01, "R4 select");
    rd(2'd2, 8'h02, "R10 high kept");
    rd(2'd1, 8'h02, "R10 low kept");
    pulse(1'b1, 2);
    rd(2'd2, 8'h02, "R4 high pin ignored");
    // wrap low: 02 + 254 -> 00, carry into high (R3, R4)
    pulse(1'b0, 254);
    rd(2'd1, 8'h00, "R3 low wrap");
    rd(2'd2, 8'h03, "R4 carry");
    // independent: high wraps 03 + 253 -> 00 (R5)
    wr(2'd0, 8'h00);
    pulse(1'b1, 253);
    rd(2'd2, 8'h00, "R5 high wrap");
    pulse(1'b0, 256);
    rd(2'd1, 8'h00, "R5 low wrapped");
    rd(2'd2, 8'h00, "R5 no carry");
    // clear collides with a count edge (R6)
    pulse(1'b0, 1);
    pulse(1'b1, 1);
    @(negedge clk_i); evt_lo_i = 1'b1; evt_hi_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 2'd0; bus_wdata_i = 8'h06;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
    evt_lo_i = 1'b0; evt_hi_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rd(2'd1, 8'h00, "R6 clear beats count low");
    rd(2'd2, 8'h00, "R6 clear beats count high");
    // reset mid-run (R1)
    wr(2'd3, 8'h12);
    pulse(1'b0, 1);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd(2'd1, 8'h00, "R1 low after reset");
    rd(2'd3, 8'hFF, "R1 clock-stop after reset");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule